// File: doc/BRIEF.md
# Line-Locked Digital Receive Clock Recovery Loop

This block rebuilds a line-synchronous 1.536 MHz bit clock inside a basic-rate S/T receiver. It counts a tick enable at twice the 7.68 MHz crystal rate (15.36 MHz), so one nominal recovered cycle is ten ticks. Each tick is half a crystal period. When the receiver reports a framing-bit transition, the block measures where that transition falls within the current recovered cycle. It then stretches or shrinks the following cycle by one tick or two ticks, which is half or one whole crystal period.

A 768 kHz clock is derived from the recovered clock by dividing it by two. A frame counter runs on recovered cycles and drives a one-clock frame-sync strobe. A lock flag is raised once a run of consecutive good code-violation pairs has been reported. At that moment the frame counter is realigned once, so that frame sync starts at a fixed phase. While unlocked, the loop keeps tracking, but frame sync stays low.

Top module: `line_dpll`

## Requirements
- R1: While reset is asserted, recClk is 1, halfClk is 0, frameSync is 0 and frameLock is 0.
- R2: With no framing events, every recovered cycle is NOM_TICKS (10) ticks long, high for the first 5 ticks and low for the rest.
- R3: A framing event seen when the cycle count is 1 or 2, or 8 or 9, is corrected by one tick. An early-half position lengthens the cycle to 11 and a late-half position shortens it to 9.
- R4: A framing event whose error is larger than 2 ticks is corrected by two ticks. Counts 3 and 4 give a 12-tick cycle, and counts 5 to 7 give an 8-tick cycle. An event at count 0 leaves the cycle at 10.
- R5: A correction is applied only to the cycle that follows the cycle holding the event. The cycle after that is nominal again.
- R6: halfClk toggles at every rising edge of recClk and at no other time.
- R7: While tickEn is low, recClk and halfClk hold their values.
- R8: frameLock rises on the third consecutive pairGood pulse, and not before it.
- R9: A pairBad pulse clears frameLock on the next clock and restarts the count of good pairs.
- R10: frameSync stays low while frameLock is low. Once lock is reached, the first pulse comes at the first recClk rising edge after lock, and each later pulse comes FRAME_CYC (192) rising edges after the one before.
- R11: With framing events spaced four nominal cycles apart and jittered by up to one tick, every cycle stays between 8 and 12 ticks. After the jitter stops, all cycles return to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Half-crystal-period tick enable (15.36 MHz rate) |
| lineEdge | input | 1 | Framing-bit transition event, valid only with tickEn |
| pairGood | input | 1 | One valid code-violation pair was seen |
| pairBad | input | 1 | An expected code-violation pair was missing |
| recClk | output | 1 | Recovered 1.536 MHz clock |
| halfClk | output | 1 | Recovered clock divided by two (768 kHz) |
| frameSync | output | 1 | One-clock frame-sync strobe, only while locked |
| frameLock | output | 1 | Frame lock flag |

## Verification
The properties assume the following about the inputs:
- lineEdge is meaningful only in a cycle where tickEn is high.
- Framing events are spaced several recovered cycles apart, so that every cycle length stays within two ticks of nominal.
- pairGood and pairBad are single-clock pulses.

The stimulus meets these assumptions:
- tickEn is held high except during one deliberate stall, in which no event is sent.
- Each event is placed a known number of ticks after an observed recClk rise.
- Tracking events are spaced forty ticks apart, with at most one tick of jitter.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic adjValid;   // apply a correction to the next cycle
    logic adjLonger;  // 1: stretch, 0: shrink
    logic adjFull;    // 1: whole crystal period, 0: half
    logic realign;    // force the frame counter to its lock phase
  } dpllCtl_t;
endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int NOM_TICKS   = 10,
  parameter int STEP_FINE   = 1,
  parameter int STEP_COARSE = 2,
  parameter int FRAME_CYC   = 192,
  parameter int CW          = $clog2(NOM_TICKS + STEP_COARSE + 1),
  parameter int FW          = $clog2(FRAME_CYC)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  dpllCtl_t      ctl,
  input  logic          lockedIn,
  output logic [CW-1:0] phaseCnt,
  output logic [CW-1:0] curLen,
  output logic          cycEnd,
  output logic          recClk,
  output logic          halfClk,
  output logic          frameSync
);
  localparam logic [CW-1:0] NOM_L  = CW'(NOM_TICKS);
  localparam logic [CW-1:0] HIGH_L = CW'(NOM_TICKS / 2);
  localparam logic [CW-1:0] FINE_L = CW'(STEP_FINE);
  localparam logic [CW-1:0] CRS_L  = CW'(STEP_COARSE);
  localparam logic [FW-1:0] FMAX   = FW'(FRAME_CYC - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic [CW-1:0] nextLen;
  logic [CW-1:0] step;
  logic [FW-1:0] frameCnt;
  logic          frameWrap;

  assign phaseCnt  = cnt;
  assign curLen    = len;
  assign cycEnd    = tickEn && (cnt == len - 1'b1);
  assign recClk    = (cnt < HIGH_L);
  assign frameWrap = (frameCnt == FMAX);

  // length of the cycle about to start
  always_comb begin
    step = ctl.adjFull ? CRS_L : FINE_L;
    if (!ctl.adjValid)     nextLen = NOM_L;
    else if (ctl.adjLonger) nextLen = NOM_L + step;
    else                    nextLen = NOM_L - step;
  end

  // tick counter, cycle length and divide-by-two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      len     <= NOM_L;
      halfClk <= 1'b0;
    end else if (tickEn) begin
      if (cycEnd) begin
        cnt     <= '0;
        len     <= nextLen;
        halfClk <= ~halfClk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // frame counter and sync strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt  <= '0;
      frameSync <= 1'b0;
    end else begin
      frameSync <= 1'b0;
      if (ctl.realign) begin
        frameCnt <= FMAX;
      end else if (cycEnd) begin
        frameCnt  <= frameWrap ? '0 : frameCnt + 1'b1;
        frameSync <= lockedIn && frameWrap;
      end
    end
  end
endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
#(
  parameter int NOM_TICKS  = 10,
  parameter int FINE_LIMIT = 2,
  parameter int LOCK_PAIRS = 3,
  parameter int CW         = $clog2(NOM_TICKS + 3),
  parameter int GW         = $clog2(LOCK_PAIRS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          lineEdge,
  input  logic          pairGood,
  input  logic          pairBad,
  input  logic [CW-1:0] phaseCnt,
  input  logic [CW-1:0] curLen,
  input  logic          cycEnd,
  output dpllCtl_t      ctl,
  output logic          frameLock
);
  localparam logic [CW-1:0] HALF_L  = CW'(NOM_TICKS / 2);
  localparam logic [CW-1:0] LIMIT_L = CW'(FINE_LIMIT);
  localparam logic [GW-1:0] LAST_G  = GW'(LOCK_PAIRS - 1);

  logic          edgeSeen;
  logic          earlyHalf;
  logic [CW-1:0] errMag;
  dpllCtl_t      newCorr;
  dpllCtl_t      pending;
  logic [GW-1:0] goodCnt;
  logic          lockNow;

  // phase error of the framing event against the cycle start
  assign edgeSeen  = lineEdge && tickEn;
  assign earlyHalf = (phaseCnt < HALF_L);
  assign errMag    = earlyHalf ? phaseCnt : (curLen - phaseCnt);

  always_comb begin
    newCorr           = '0;
    newCorr.adjValid  = (phaseCnt != '0);
    newCorr.adjLonger = earlyHalf;
    newCorr.adjFull   = (errMag > LIMIT_L);
  end

  // one correction held until the next cycle boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (edgeSeen && !cycEnd) begin
      pending <= newCorr;
    end else if (cycEnd) begin
      pending <= '0;
    end
  end

  // lock tracking on code-violation pairs
  assign lockNow = pairGood && !pairBad && !frameLock && (goodCnt == LAST_G);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt   <= '0;
      frameLock <= 1'b0;
    end else if (pairBad) begin
      goodCnt   <= '0;
      frameLock <= 1'b0;
    end else if (pairGood && !frameLock) begin
      if (lockNow) begin
        frameLock <= 1'b1;
        goodCnt   <= '0;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = edgeSeen ? newCorr : pending;
    ctl.realign = lockNow;
  end
endmodule

// File: rtl/line_dpll.sv
module line_dpll
  import dpll_pkg::*;
#(
  parameter int NOM_TICKS   = 10,
  parameter int FINE_LIMIT  = 2,
  parameter int STEP_FINE   = 1,
  parameter int STEP_COARSE = 2,
  parameter int FRAME_CYC   = 192,
  parameter int LOCK_PAIRS  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic lineEdge,
  input  logic pairGood,
  input  logic pairBad,
  output logic recClk,
  output logic halfClk,
  output logic frameSync,
  output logic frameLock
);
  localparam int CW = $clog2(NOM_TICKS + STEP_COARSE + 1);

  dpllCtl_t      ctl;
  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] curLen;
  logic          cycEnd;

  dpll_control #(
    .NOM_TICKS (NOM_TICKS),
    .FINE_LIMIT(FINE_LIMIT),
    .LOCK_PAIRS(LOCK_PAIRS),
    .CW        (CW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .lineEdge (lineEdge),
    .pairGood (pairGood),
    .pairBad  (pairBad),
    .phaseCnt (phaseCnt),
    .curLen   (curLen),
    .cycEnd   (cycEnd),
    .ctl      (ctl),
    .frameLock(frameLock)
  );

  dpll_datapath #(
    .NOM_TICKS  (NOM_TICKS),
    .STEP_FINE  (STEP_FINE),
    .STEP_COARSE(STEP_COARSE),
    .FRAME_CYC  (FRAME_CYC),
    .CW         (CW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .ctl      (ctl),
    .lockedIn (frameLock),
    .phaseCnt (phaseCnt),
    .curLen   (curLen),
    .cycEnd   (cycEnd),
    .recClk   (recClk),
    .halfClk  (halfClk),
    .frameSync(frameSync)
  );
endmodule

// File: rtl/line_dpll_chk.sv
module line_dpll_chk #(
  parameter int NOM_TICKS   = 10,
  parameter int STEP_COARSE = 2
) (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic pairGood,
  input logic pairBad,
  input logic recClk,
  input logic halfClk,
  input logic frameSync,
  input logic frameLock
);
  logic       rcQ;
  logic       seenRise;
  logic [7:0] tickSince;
  logic       riseNow;

  assign riseNow = recClk && !rcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcQ       <= 1'b1;
      seenRise  <= 1'b0;
      tickSince <= '0;
    end else begin
      rcQ <= recClk;
      if (riseNow) begin
        seenRise  <= 1'b1;
        tickSince <= tickEn ? 8'd1 : 8'd0;
      end else if (tickEn) begin
        tickSince <= tickSince + 8'd1;
      end
    end
  end

  // R11
  cycle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseNow && seenRise) |-> (tickSince >= 8'(NOM_TICKS - STEP_COARSE)) &&
                              (tickSince <= 8'(NOM_TICKS + STEP_COARSE)));

  // R6
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recClk) |-> (halfClk != $past(halfClk)));

  // R6
  half_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(recClk) |-> $stable(halfClk));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(recClk) && $stable(halfClk)));

  // R9
  bad_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairBad |=> !frameLock);

  // R8
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLock) |-> $past(pairGood));

  // R10
  sync_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> ($past(frameLock) && $rose(recClk)));
endmodule

bind line_dpll line_dpll_chk #(
  .NOM_TICKS  (NOM_TICKS),
  .STEP_COARSE(STEP_COARSE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .pairGood (pairGood),
  .pairBad  (pairBad),
  .recClk   (recClk),
  .halfClk  (halfClk),
  .frameSync(frameSync),
  .frameLock(frameLock)
);

// File: tb/line_dpll_tb.sv
`timescale 1ns/1ps
module line_dpll_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic lineEdge = 1'b0;
  logic pairGood = 1'b0;
  logic pairBad = 1'b0;
  logic recClk, halfClk, frameSync, frameLock;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // monitor state
  int cyc = 0;
  int riseN = 0;
  int lastRiseCyc = 0;
  int lastPer = 0;
  int lastHigh = 0;
  int minPer = 1000;
  int maxPer = 0;
  int offNom = 0;
  int halfErr = 0;
  int syncN = 0;
  int lastSyncRise = 0;
  int prevSyncRise = 0;
  int syncUnlocked = 0;
  bit haveRise = 1'b0;
  bit rcPrev = 1'b1;
  bit halfPrev = 1'b0;
  bit halfAtRise = 1'b0;
  bit lockPrev = 1'b0;

  always #5 clk = ~clk;

  line_dpll u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineEdge(lineEdge),
    .pairGood(pairGood), .pairBad(pairBad), .recClk(recClk),
    .halfClk(halfClk), .frameSync(frameSync), .frameLock(frameLock)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rstN) begin
      if (recClk && !rcPrev) begin
        riseN++;
        if (haveRise) begin
          lastPer = cyc - lastRiseCyc;
          if (lastPer < minPer) minPer = lastPer;
          if (lastPer > maxPer) maxPer = lastPer;
          if (lastPer != 10) offNom++;
        end
        haveRise = 1'b1;
        lastRiseCyc = cyc;
        if (halfClk == halfAtRise) halfErr++;
        halfAtRise = halfClk;
      end else if (halfClk != halfPrev) begin
        halfErr++;
      end
      if (!recClk && rcPrev) lastHigh = cyc - lastRiseCyc;
      if (frameSync) begin
        syncN++;
        prevSyncRise = lastSyncRise;
        lastSyncRise = riseN;
        if (!lockPrev) syncUnlocked++;
      end
    end
    rcPrev = recClk;
    halfPrev = halfClk;
    lockPrev = frameLock;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitRises(input int target);
    while (riseN < target) @(negedge clk);
  endtask

  // align to the negedge right after a recClk rise; returns rise index
  task automatic syncToRise(output int base);
    int start;
    start = riseN;
    while (riseN == start) @(negedge clk);
    base = riseN;
  endtask

  task automatic pulseGood();
    pairGood = 1'b1; @(negedge clk); pairGood = 1'b0;
  endtask

  task automatic pulseBad();
    pairBad = 1'b1; @(negedge clk); pairBad = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(recClk == 1'b1, "R1", "recClk in reset", recClk, 1);
    chk(halfClk == 1'b0, "R1", "halfClk in reset", halfClk, 0);
    chk(frameSync == 1'b0, "R1", "frameSync in reset", frameSync, 0);
    chk(frameLock == 1'b0, "R1", "frameLock in reset", frameLock, 0);
  endtask

  task automatic testNominal();
    waitRises(riseN + 4);
    chk(lastPer == 10, "R2", "free-run period", lastPer, 10);
    chk(lastHigh == 5, "R2", "free-run high time", lastHigh, 5);
  endtask

  // R3 R4 R5: event at count k, next cycle length expLen, then nominal
  task automatic testStep(input int k, input int expLen, input string req);
    int base;
    int per1;
    syncToRise(base);
    repeat (k) @(negedge clk);
    lineEdge = 1'b1;
    @(negedge clk);
    lineEdge = 1'b0;
    waitRises(base + 2);
    per1 = lastPer;
    waitRises(base + 3);
    chk(per1 == expLen, req, $sformatf("corrected cycle for count %0d", k), per1, expLen);
    chk(lastPer == 10, "R5", $sformatf("cycle after correction, count %0d", k), lastPer, 10);
  endtask

  task automatic testStall();
    bit rc0, hc0;
    int r0;
    @(negedge clk);
    tickEn = 1'b0;
    rc0 = recClk; hc0 = halfClk; r0 = riseN;
    repeat (25) @(negedge clk);
    chk(recClk == rc0 && halfClk == hc0, "R7", "outputs held during stall",
        {recClk, halfClk}, {rc0, hc0});
    chk(riseN == r0, "R7", "no rise during stall", riseN - r0, 0);
    tickEn = 1'b1;
    waitRises(riseN + 3);
  endtask

  task automatic testLock();
    int base, s0;
    syncToRise(base);
    pulseGood(); pulseGood(); pulseBad(); pulseGood(); pulseGood();
    chk(frameLock == 1'b0, "R9", "lock after bad pair then two good", frameLock, 0);
    chk(frameLock == 1'b0, "R8", "two consecutive good pairs not enough", frameLock, 0);
    pulseGood();
    chk(frameLock == 1'b1, "R8", "lock on third consecutive good", frameLock, 1);
    chk(syncN == 0 && syncUnlocked == 0, "R10", "no sync before lock", syncN, 0);
    while (syncN < 1) @(negedge clk);
    chk(lastSyncRise == base + 1, "R10", "first sync rise index", lastSyncRise, base + 1);
    while (syncN < 2) @(negedge clk);
    chk(lastSyncRise - prevSyncRise == 192, "R10", "sync spacing in cycles",
        lastSyncRise - prevSyncRise, 192);
    pulseBad();
    chk(frameLock == 1'b0, "R9", "bad pair clears lock", frameLock, 0);
    s0 = syncN;
    waitRises(riseN + 400);
    chk(syncN == s0, "R10", "no sync while unlocked", syncN - s0, 0);
    chk(syncUnlocked == 0, "R10", "syncs seen while unlocked", syncUnlocked, 0);
  endtask

  task automatic testTrack();
    int base;
    int offs[20] = '{0,0,0,0,0,0, 1,-1,1,0,-1,1,-1,0, 0,0,0,0,0,0};
    syncToRise(base);
    repeat (5) @(negedge clk);
    minPer = 1000; maxPer = 0;
    for (int n = 0; n < 20; n++) begin
      if (n > 0) repeat (40 + offs[n] - offs[n-1] - 1) @(negedge clk);
      lineEdge = 1'b1;
      @(negedge clk);
      lineEdge = 1'b0;
      if (n == 16) offNom = 0;
    end
    repeat (20) @(negedge clk);
    chk(minPer >= 8, "R11", "shortest tracked cycle", minPer, 8);
    chk(maxPer <= 12, "R11", "longest tracked cycle", maxPer, 12);
    chk(offNom == 0, "R11", "off-nominal cycles after settling", offNom, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testNominal();
    testStep(0, 10, "R4");
    testStep(1, 11, "R3");
    testStep(2, 11, "R3");
    testStep(3, 12, "R4");
    testStep(4, 12, "R4");
    testStep(5, 8, "R4");
    testStep(7, 8, "R4");
    testStep(8, 9, "R3");
    testStep(9, 9, "R3");
    testStall();
    testTrack();
    testLock();
    chk(halfErr == 0, "R6", "halfClk toggle mismatches", halfErr, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule